// File: doc/BRIEF.md
# Byte-Wide FIFO Command Receiver

This block pulls host commands out of an 8-bit synchronous bridge FIFO that runs on its own 60 MHz clock. It drives the FIFO's active-low output-enable and read strobes from a three-state read sequencer: idle, then one cycle of output-enable lead, then reading. In the reading state it takes one byte on every FIFO clock edge. Four consecutive bytes make one command word.

Each finished command is handed to the 100 MHz system domain through a toggle handshake. Consumers there see a single-cycle valid strobe together with an 8-bit opcode, an 8-bit address and a 16-bit value. If the host withdraws its data-available flag partway through a frame, the partial command is thrown away. The block only reads the shared data bus and never drives it.

Top module: `fifo_cmd_rx`

## Requirements
- R1: Bytes are taken in the order opcode, address, value high, value low. They appear on `cmdOp`, `cmdAddr` and `cmdValue` = {high, low}, so `cmdValue[15:8]` is the third byte.
- R2: While `rxAvailN` is high and the sequencer is idle, `oeN` and `rdN` stay high. The sequencer leaves idle only on a FIFO clock edge that sees `rxAvailN` low.
- R3: `oeN` goes low one FIFO cycle before `rdN` goes low. `rdN` is low only while `oeN` is low.
- R4: In the reading state one byte is captured per FIFO edge on four back-to-back edges. After the edge that captures the fourth byte, `oeN` and `rdN` are both high.
- R5: If `rxAvailN` goes high before the fourth byte, the partial command yields no `cmdValid`, both strobes return high, and the next frame assembles from a fresh opcode.
- R6: Each complete command produces exactly one `cmdValid` pulse lasting one `sysClk` cycle. `cmdOp`, `cmdAddr` and `cmdValue` change only in a cycle where `cmdValid` is high.
- R7: With `rxAvailN` held low across back-to-back commands, every command is delivered in order and none is dropped. The outputs hold the last command afterwards.
- R8: The block leaves `fifoData` undriven. The byte the host places on the bus is seen there unaltered while reading.
- R9: While `rstN` is low, `oeN` and `rdN` are high, `cmdValid` is low and the command outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fifoClk | input | 1 | Bridge FIFO clock (60 MHz) |
| sysClk | input | 1 | System clock of the consumer (100 MHz) |
| rstN | input | 1 | Active-low asynchronous reset, both domains |
| rxAvailN | input | 1 | Active-low flag: FIFO holds data for the block |
| fifoData | inout | 8 | Shared data bus, only read by this block |
| oeN | output | 1 | Active-low output enable to the FIFO |
| rdN | output | 1 | Active-low read strobe to the FIFO |
| cmdValid | output | 1 | One-cycle strobe in sysClk: new command present |
| cmdOp | output | 8 | Opcode byte of the last command |
| cmdAddr | output | 8 | Address byte of the last command |
| cmdValue | output | 16 | Value of the last command, high byte first on the bus |

## Verification
The embedded properties watch these rules on every cycle:
- The output-enable lead before each read strobe.
- The sequencer staying idle while no data is flagged.
- The release of both strobes after the fourth byte.
- The handshake toggle moving only on a completed frame, and never on a discard.
- The one-cycle width of `cmdValid`.
- The command outputs staying stable between pulses.

Byte ordering, bit-exact transfer across the clock boundary, dropping of aborted frames and lossless delivery of back-to-back bursts depend on data values and counts. Only the bench's scenarios can show these.

// File: rtl/fifo_cmd_pkg.sv
package fifo_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_BYTES = 4;
  localparam int CMD_W     = BYTE_W * CMD_BYTES;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_OE   = 2'd1,
    RD_READ = 2'd2
  } rdState_t;

  // strobes from the read sequencer to the byte datapath
  typedef struct packed {
    logic capture;
    logic discard;
  } rdStrobe_t;
endpackage

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
  import fifo_cmd_pkg::*;
(
  input  logic      fifoClk,
  input  logic      rstN,
  input  logic      rxAvailN,
  input  logic      lastByte,
  output rdStrobe_t strobes,
  output logic      oeN,
  output logic      rdN
);
  rdState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      RD_IDLE: if (!rxAvailN) stateNext = RD_OE;
      RD_OE:   stateNext = rxAvailN ? RD_IDLE : RD_READ;
      RD_READ: if (rxAvailN || lastByte) stateNext = RD_IDLE;
      default: stateNext = RD_IDLE;
    endcase
  end

  always_ff @(posedge fifoClk or negedge rstN) begin
    if (!rstN) state <= RD_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.capture = (state == RD_READ) && !rxAvailN;
    strobes.discard = (state != RD_IDLE) && rxAvailN;
    oeN = (state == RD_IDLE);
    rdN = (state != RD_READ);
  end

  // R3
  oe_lead_chk: assert property (@(posedge fifoClk) disable iff (!rstN)
    $fell(rdN) |-> ($past(rdN) && !$past(oeN)));

  // R2
  idle_hold_chk: assert property (@(posedge fifoClk) disable iff (!rstN)
    (oeN && rxAvailN) |=> oeN);

  // R4
  release_after_last_chk: assert property (@(posedge fifoClk) disable iff (!rstN)
    (strobes.capture && lastByte) |=> (oeN && rdN));
endmodule

// File: rtl/fifo_rd_datapath.sv
module fifo_rd_datapath
  import fifo_cmd_pkg::*;
#(
  parameter int BYTES = CMD_BYTES,
  parameter int BW    = BYTE_W
) (
  input  logic              fifoClk,
  input  logic              rstN,
  input  rdStrobe_t         strobes,
  input  logic [BW-1:0]     busIn,
  output logic              lastByte,
  output logic [BYTES*BW-1:0] holdWord,
  output logic              holdToggle
);
  localparam int WORD_W = BYTES * BW;
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int ASM_W  = WORD_W - BW;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  logic [IDX_W-1:0] byteIdx;
  logic [ASM_W-1:0] asmReg;

  assign lastByte = (byteIdx == LAST_IDX);

  always_ff @(posedge fifoClk or negedge rstN) begin
    if (!rstN) begin
      byteIdx    <= '0;
      asmReg     <= '0;
      holdWord   <= '0;
      holdToggle <= 1'b0;
    end else if (strobes.discard) begin
      byteIdx <= '0;
    end else if (strobes.capture) begin
      if (lastByte) begin
        holdWord   <= {asmReg, busIn};
        holdToggle <= ~holdToggle;
        byteIdx    <= '0;
      end else begin
        asmReg  <= {asmReg[ASM_W-BW-1:0], busIn};
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  // R6
  toggle_on_last_chk: assert property (@(posedge fifoClk) disable iff (!rstN)
    !$stable(holdToggle) |-> $past(strobes.capture && lastByte));

  // R5
  discard_no_toggle_chk: assert property (@(posedge fifoClk) disable iff (!rstN)
    strobes.discard |=> $stable(holdToggle));
endmodule

// File: rtl/cmd_cdc.sv
module cmd_cdc #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] holdWord,
  input  logic              holdToggle,
  output logic              cmdValid,
  output logic [WORD_W-1:0] cmdWord
);
  logic [SYNC_STAGES:0] syncQ;
  logic                 togglePulse;

  assign togglePulse = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      cmdValid <= 1'b0;
      cmdWord  <= '0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-1:0], holdToggle};
      cmdValid <= togglePulse;
      if (togglePulse) cmdWord <= holdWord;
    end
  end

  // R6
  valid_single_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R6
  word_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !$stable(cmdWord) |-> cmdValid);
endmodule

// File: rtl/fifo_cmd_rx.sv
module fifo_cmd_rx
  import fifo_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        fifoClk,
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        rxAvailN,
  inout  wire  [7:0]  fifoData,
  output logic        oeN,
  output logic        rdN,
  output logic        cmdValid,
  output logic [7:0]  cmdOp,
  output logic [7:0]  cmdAddr,
  output logic [15:0] cmdValue
);
  rdStrobe_t        strobes;
  logic             lastByte;
  logic [CMD_W-1:0] holdWord;
  logic             holdToggle;
  logic [CMD_W-1:0] cmdWord;

  fifo_rd_ctrl u_ctrl (
    .fifoClk (fifoClk),
    .rstN    (rstN),
    .rxAvailN(rxAvailN),
    .lastByte(lastByte),
    .strobes (strobes),
    .oeN     (oeN),
    .rdN     (rdN)
  );

  fifo_rd_datapath #(.BYTES(CMD_BYTES), .BW(BYTE_W)) u_dp (
    .fifoClk   (fifoClk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busIn     (fifoData),
    .lastByte  (lastByte),
    .holdWord  (holdWord),
    .holdToggle(holdToggle)
  );

  cmd_cdc #(.WORD_W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .holdWord  (holdWord),
    .holdToggle(holdToggle),
    .cmdValid  (cmdValid),
    .cmdWord   (cmdWord)
  );

  assign cmdOp    = cmdWord[31:24];
  assign cmdAddr  = cmdWord[23:16];
  assign cmdValue = cmdWord[15:0];
endmodule

// File: tb/fifo_cmd_rx_test.sv
`timescale 1ns/1ps
module fifo_cmd_rx_test;
  localparam real SYS_PERIOD  = 10.0;
  localparam real FIFO_PERIOD = 16.667;
  localparam int  NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01_00_0002, 32'h03_00_1234, 32'h10_7F_07D0,
    32'hFF_FF_FFFF, 32'h00_00_0000, 32'h2D_A5_5A24
  };

  logic sysClk = 0, fifoClk = 0, rstN = 0, rxAvailN = 1;
  logic [7:0] drvVal = 0;
  logic drvEn = 0;
  wire  [7:0] fifoData;
  logic oeN, rdN, cmdValid;
  logic [7:0] cmdOp, cmdAddr;
  logic [15:0] cmdValue;

  assign fifoData = drvEn ? drvVal : 8'hzz;

  always #(SYS_PERIOD/2)  sysClk  = ~sysClk;
  always #(FIFO_PERIOD/2) fifoClk = ~fifoClk;

  fifo_cmd_rx uut (
    .fifoClk(fifoClk), .sysClk(sysClk), .rstN(rstN), .rxAvailN(rxAvailN),
    .fifoData(fifoData), .oeN(oeN), .rdN(rdN), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdValue(cmdValue)
  );

  int checks = 0, failures = 0, rxCount = 0;
  logic [31:0] rxLog [32];
  logic prevValid = 0, widePulse = 0;

  always @(negedge sysClk) begin
    if (cmdValid) begin
      if (rxCount < 32) rxLog[rxCount] = {cmdOp, cmdAddr, cmdValue};
      rxCount++;
      if (prevValid) widePulse = 1;
    end
    prevValid = cmdValid;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at a fifoClk negedge; returns at the negedge after the 4th capture
  task automatic sendCmd(input logic [31:0] w, input bit keep);
    rxAvailN = 0; drvEn = 1; drvVal = w[31:24];
    @(negedge fifoClk);
    check(!oeN && rdN, "R3 oe lead", {oeN, rdN}, 2'b01);
    @(negedge fifoClk);
    check(!oeN && !rdN, "R3 read phase", {oeN, rdN}, 2'b00);
    check(fifoData == w[31:24], "R8 bus undriven", fifoData, w[31:24]);
    @(negedge fifoClk); drvVal = w[23:16];
    @(negedge fifoClk); drvVal = w[15:8];
    @(negedge fifoClk); drvVal = w[7:0];
    @(negedge fifoClk);
    check(oeN && rdN, "R4 release after 4th byte", {oeN, rdN}, 2'b11);
    if (!keep) begin rxAvailN = 1; drvEn = 0; end
  endtask

  task automatic settle();
    repeat (10) @(negedge sysClk);
    @(negedge fifoClk);
  endtask

  bit finished = 0;

  initial begin
    int base;
    repeat (3) @(negedge sysClk);
    // R9 reset state
    check(oeN && rdN && !cmdValid, "R9 strobes in reset", {oeN, rdN, cmdValid}, 3'b110);
    check({cmdOp, cmdAddr, cmdValue} == 0, "R9 outputs in reset", {cmdOp, cmdAddr, cmdValue}, 0);
    rstN = 1;
    // R2 idle while no data flagged
    repeat (8) @(negedge fifoClk);
    check(oeN && rdN, "R2 idle without data", {oeN, rdN}, 2'b11);

    // table walk: R1, R6
    for (int i = 0; i < NVEC; i++) begin
      base = rxCount;
      sendCmd(VEC[i], 0);
      settle();
      check(rxCount == base + 1, "R6 one pulse per command", rxCount, base + 1);
      check({cmdOp, cmdAddr, cmdValue} == VEC[i], "R1 byte order", {cmdOp, cmdAddr, cmdValue}, VEC[i]);
      check(cmdValue[15:8] == VEC[i][15:8], "R1 value high byte", cmdValue[15:8], VEC[i][15:8]);
    end
    check(!widePulse, "R6 pulse width", widePulse, 0);

    // R5 abort after two bytes
    base = rxCount;
    rxAvailN = 0; drvEn = 1; drvVal = 8'hE1;
    @(negedge fifoClk); @(negedge fifoClk);
    @(negedge fifoClk); drvVal = 8'hE2;
    @(negedge fifoClk); rxAvailN = 1; drvEn = 0;
    @(negedge fifoClk);
    check(oeN && rdN, "R5 strobes released on abort", {oeN, rdN}, 2'b11);
    settle();
    check(rxCount == base, "R5 no pulse for partial", rxCount, base);
    sendCmd(32'h21_04_0010, 0);
    settle();
    check({cmdOp, cmdAddr, cmdValue} == 32'h21_04_0010, "R5 fresh frame after abort",
          {cmdOp, cmdAddr, cmdValue}, 32'h21_04_0010);

    // R5 abort during output-enable lead
    base = rxCount;
    rxAvailN = 0; drvEn = 1; drvVal = 8'h99;
    @(negedge fifoClk); rxAvailN = 1; drvEn = 0;
    @(negedge fifoClk);
    check(oeN && rdN, "R5 abort in lead state", {oeN, rdN}, 2'b11);
    settle();
    check(rxCount == base, "R5 no pulse after lead abort", rxCount, base);

    // R7 back-to-back burst
    base = rxCount;
    sendCmd(32'h03_00_AAAA, 1);
    sendCmd(32'h03_00_BBBB, 1);
    sendCmd(32'h15_00_0030, 1);
    sendCmd(32'h03_00_CCCC, 0);
    settle();
    check(rxCount == base + 4, "R7 none dropped", rxCount, base + 4);
    check(rxLog[base] == 32'h03_00_AAAA, "R7 first of burst", rxLog[base], 32'h03_00_AAAA);
    check(rxLog[base+2] == 32'h15_00_0030, "R7 third of burst", rxLog[base+2], 32'h15_00_0030);
    check({cmdOp, cmdAddr, cmdValue} == 32'h03_00_CCCC, "R7 last value held",
          {cmdOp, cmdAddr, cmdValue}, 32'h03_00_CCCC);
    check(!widePulse, "R6 pulse width in burst", widePulse, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(SYS_PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule